// File: doc/BRIEF.md
# Endpoint Interrupt Aggregator with End-of-Interrupt Re-arm

This block sits between a USB OTG controller core and the CPU. It collects per-endpoint transmit events, per-endpoint receive events, eight core-level bus events and one VBUS-drive event into a single raw event word. Software can see that word raw or filtered by an enable mask. A single CPU interrupt line goes high when any enabled event is pending.

Software sets and clears both the raw event word and the enable mask with write-one ports. Once the CPU line rises, it stays high until software writes the end-of-interrupt offset. The line then drops for exactly one cycle. It rises again on the next cycle if enabled events are still pending, so a second edge is never lost.

The block also has three more registers. An identifier register returns a fixed non-zero constant. A control register pulses a soft reset to the controller core. A status register shows the live VBUS-drive level. Software reaches all registers through a simple 32-bit word bus.

Top module: `usb_irq_gate`

## Requirements
- R1: After reset the event word, enable mask, CPU line, soft-reset pulse and read data are all zero. A read of offset 0x00 returns the non-zero parameter `REV_ID` (default 0x4D55_0100).
- R2: Event inputs map to fixed bits in the event word. Transmit endpoint i goes to bit i (bits 0..4). Receive endpoint j (j = 1..4, port bit j-1) goes to bit 8+j. Core event k goes to bit 16+k. The VBUS-drive event goes to bit 24. Every other bit, bit 8 included, always reads 0, so the valid pattern is 0x01FF_1E1F.
- R3: A write to 0x24 sets the event bits written as 1. A write to 0x28 clears the event bits written as 1. A hardware event arriving in the same cycle as a clear of its bit leaves that bit set. Reading 0x20 returns the event word.
- R4: A write to 0x30 sets the mask bits written as 1. A write to 0x34 clears the mask bits written as 1. Reading 0x2c returns the mask, restricted to the valid pattern.
- R5: Reading 0x38 returns the bitwise AND of the event word and the mask.
- R6: The CPU line goes high one cycle after the masked word becomes non-zero while the line is low. It then stays high, even if the events are cleared, until an end-of-interrupt write.
- R7: Any write to 0x3c, whatever its data, drives the CPU line low in the next cycle. If masked events are still pending the line goes high again one cycle later. Otherwise it stays low.
- R8: Writing 0x04 with bit 0 set produces a one-cycle soft-reset pulse in the next cycle. Bit 0 clear produces no pulse. Offset 0x04 reads 0.
- R9: Reading 0x08 returns the live VBUS-drive level in bit 0 and zero in every other bit.
- R10: Writes to 0x00, 0x08, 0x20, 0x2c and 0x38 change no state.
- R11: Read data appears on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tx_ep_evt | input | TX_EPS | Transmit endpoint event pulses |
| rx_ep_evt | input | RX_EPS | Receive endpoint event pulses (endpoints 1..RX_EPS) |
| core_evt | input | CORE_EVTS | Core-level bus event pulses |
| vbus_drv_evt | input | 1 | VBUS-drive change event pulse |
| vbus_drv_lvl | input | 1 | Live VBUS-drive level |
| cpu_irq | output | 1 | Interrupt line to the CPU |
| core_soft_rst | output | 1 | One-cycle soft-reset pulse to the controller core |

## Verification
The assertions assume one register access per cycle, at a word-aligned offset. They also assume event inputs are clean synchronous levels sampled at each edge, whether they are held or pulsed. The stimulus drives every input on the falling edge, issues a single read or write strobe at a time, and pulses events for whole cycles. It deliberately combines a hardware event with a clear of the same bit, and an end-of-interrupt write with pending enabled events. The per-cycle reference model predicts the line, the pulse and the read data from the register offsets alone.

// File: rtl/usb_irq_gate_pkg.sv
package usb_irq_gate_pkg;
  localparam int unsigned OFF_REV      = 8'h00;
  localparam int unsigned OFF_CTRL     = 8'h04;
  localparam int unsigned OFF_STAT     = 8'h08;
  localparam int unsigned OFF_SRC      = 8'h20;
  localparam int unsigned OFF_SRC_SET  = 8'h24;
  localparam int unsigned OFF_SRC_CLR  = 8'h28;
  localparam int unsigned OFF_MSK      = 8'h2c;
  localparam int unsigned OFF_MSK_SET  = 8'h30;
  localparam int unsigned OFF_MSK_CLR  = 8'h34;
  localparam int unsigned OFF_MASKED   = 8'h38;
  localparam int unsigned OFF_EOI      = 8'h3c;

  localparam int unsigned TX_BASE   = 0;
  localparam int unsigned RX_BASE   = 9;
  localparam int unsigned CORE_BASE = 16;
  localparam int unsigned VBUS_BIT  = 24;

  function automatic logic [31:0] valid_bits(int unsigned tx_n, int unsigned rx_n,
                                              int unsigned core_n);
    logic [31:0] v;
    v = '0;
    for (int unsigned i = 0; i < tx_n; i++)   v[TX_BASE + i]   = 1'b1;
    for (int unsigned i = 0; i < rx_n; i++)   v[RX_BASE + i]   = 1'b1;
    for (int unsigned i = 0; i < core_n; i++) v[CORE_BASE + i] = 1'b1;
    v[VBUS_BIT] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/usb_irq_setclr_reg.sv
module usb_irq_setclr_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  input  logic [W-1:0] evt_v,
  output logic [W-1:0] q
);
  // clear first, then set and hardware events OR in, so both beat a clear
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= ((q & ~clr_v) | set_v | evt_v) & VALID;
  end
endmodule

// File: rtl/usb_irq_line.sv
module usb_irq_line (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic eoi,
  output logic irq
);
  // high line means disarmed; EOI re-arms, a pending event re-fires next cycle
  always_ff @(posedge clk) begin
    if (rst)      irq <= 1'b0;
    else if (eoi) irq <= 1'b0;
    else if (pending) irq <= 1'b1;
  end
endmodule

// File: rtl/usb_irq_rdmux.sv
module usb_irq_rdmux #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [31:0] REV_ID = 32'h4D55_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic              vbus_lvl,
  input  logic [31:0]       src,
  input  logic [31:0]       msk,
  output logic [31:0]       rdata
);
  import usb_irq_gate_pkg::*;

  logic [31:0] sel;

  always_comb begin
    sel = '0;
    unique case (addr)
      ADDR_W'(OFF_REV):    sel = REV_ID;
      ADDR_W'(OFF_STAT):   sel = {31'd0, vbus_lvl};
      ADDR_W'(OFF_SRC):    sel = src;
      ADDR_W'(OFF_MSK):    sel = msk;
      ADDR_W'(OFF_MASKED): sel = src & msk;
      default:             sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
  end
endmodule

// File: rtl/usb_irq_gate.sv
module usb_irq_gate #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned TX_EPS    = 5,
  parameter int unsigned RX_EPS    = 4,
  parameter int unsigned CORE_EVTS = 8,
  parameter logic [31:0] REV_ID    = 32'h4D55_0100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic [TX_EPS-1:0]    tx_ep_evt,
  input  logic [RX_EPS-1:0]    rx_ep_evt,
  input  logic [CORE_EVTS-1:0] core_evt,
  input  logic                 vbus_drv_evt,
  input  logic                 vbus_drv_lvl,
  output logic                 cpu_irq,
  output logic                 core_soft_rst
);
  import usb_irq_gate_pkg::*;

  localparam logic [31:0] VALID = valid_bits(TX_EPS, RX_EPS, CORE_EVTS);

  logic [31:0] evt_vec, src_set, src_clr, msk_set, msk_clr;
  logic [31:0] src_q, msk_q;
  logic        eoi_wr, srst_q;

  always_comb begin
    evt_vec = '0;
    evt_vec[TX_BASE +: TX_EPS]      = tx_ep_evt;
    evt_vec[RX_BASE +: RX_EPS]      = rx_ep_evt;
    evt_vec[CORE_BASE +: CORE_EVTS] = core_evt;
    evt_vec[VBUS_BIT]               = vbus_drv_evt;
  end

  always_comb begin
    src_set = (reg_wr && reg_addr == ADDR_W'(OFF_SRC_SET)) ? reg_wdata : '0;
    src_clr = (reg_wr && reg_addr == ADDR_W'(OFF_SRC_CLR)) ? reg_wdata : '0;
    msk_set = (reg_wr && reg_addr == ADDR_W'(OFF_MSK_SET)) ? reg_wdata : '0;
    msk_clr = (reg_wr && reg_addr == ADDR_W'(OFF_MSK_CLR)) ? reg_wdata : '0;
    eoi_wr  = reg_wr && reg_addr == ADDR_W'(OFF_EOI);
  end

  usb_irq_setclr_reg #(.W(32), .VALID(VALID)) src_reg_i (
    .clk(clk), .rst(rst), .set_v(src_set), .clr_v(src_clr),
    .evt_v(evt_vec), .q(src_q)
  );

  usb_irq_setclr_reg #(.W(32), .VALID(VALID)) msk_reg_i (
    .clk(clk), .rst(rst), .set_v(msk_set), .clr_v(msk_clr),
    .evt_v(32'd0), .q(msk_q)
  );

  usb_irq_line line_i (
    .clk(clk), .rst(rst), .pending(|(src_q & msk_q)),
    .eoi(eoi_wr), .irq(cpu_irq)
  );

  usb_irq_rdmux #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) rdmux_i (
    .clk(clk), .rst(rst), .rd(reg_rd), .addr(reg_addr),
    .vbus_lvl(vbus_drv_lvl), .src(src_q), .msk(msk_q), .rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= reg_wr && reg_addr == ADDR_W'(OFF_CTRL) && reg_wdata[0];
  end
  assign core_soft_rst = srst_q;
endmodule

// File: rtl/usb_irq_gate_chk.sv
module usb_irq_gate_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [31:0] VALID  = 32'h01FF_1E1F
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              cpu_irq,
  input logic              core_soft_rst,
  input logic [31:0]       src_q,
  input logic [31:0]       msk_q
);
  logic eoi_w, ctl_w;
  assign eoi_w = reg_wr && reg_addr == ADDR_W'(8'h3c);
  assign ctl_w = reg_wr && reg_addr == ADDR_W'(8'h04) && reg_wdata[0];

  // R2
  unused_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ((src_q | msk_q) & ~VALID) == 32'd0);
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!cpu_irq && !eoi_w && (src_q & msk_q) != 32'd0) |=> cpu_irq);
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_irq && !eoi_w) |=> cpu_irq);
  // R7
  eoi_drop_chk: assert property (@(posedge clk) disable iff (rst)
    eoi_w |=> !cpu_irq);
  // R8
  srst_fire_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_w |=> core_soft_rst);
  // R8
  srst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_soft_rst && !ctl_w |=> !core_soft_rst);
endmodule

bind usb_irq_gate usb_irq_gate_chk #(.ADDR_W(ADDR_W), .VALID(VALID)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .cpu_irq(cpu_irq), .core_soft_rst(core_soft_rst),
  .src_q(src_q), .msk_q(msk_q)
);

// File: tb/usb_irq_gate_tb_top.sv
`timescale 1ns/1ps
module usb_irq_gate_tb_top;
  localparam logic [31:0] REV   = 32'h4D55_0100;
  localparam logic [31:0] VALID = 32'h01FF_1E1F;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [4:0] tx_ep_evt = 0;
  logic [3:0] rx_ep_evt = 0;
  logic [7:0] core_evt = 0;
  logic vbus_drv_evt = 0, vbus_drv_lvl = 0;
  logic cpu_irq, core_soft_rst;

  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usb_irq_gate dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_ep_evt(tx_ep_evt),
    .rx_ep_evt(rx_ep_evt), .core_evt(core_evt), .vbus_drv_evt(vbus_drv_evt),
    .vbus_drv_lvl(vbus_drv_lvl), .cpu_irq(cpu_irq), .core_soft_rst(core_soft_rst)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model: register contents as plain words
  logic [31:0] m_src = 0, m_msk = 0, m_rd = 0, ev;
  logic m_irq = 0, m_srst = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_src = 0; m_msk = 0; m_rd = 0; m_irq = 0; m_srst = 0;
    end else begin
      if (reg_rd) begin
        case (reg_addr)
          8'h00: m_rd = REV;
          8'h08: m_rd = {31'd0, vbus_drv_lvl};
          8'h20: m_rd = m_src;
          8'h2c: m_rd = m_msk;
          8'h38: m_rd = m_src & m_msk;
          default: m_rd = 0;
        endcase
      end
      m_srst = reg_wr && reg_addr == 8'h04 && reg_wdata[0];
      if (reg_wr && reg_addr == 8'h3c) m_irq = 0;
      else if ((m_src & m_msk) != 0)   m_irq = 1;
      ev = {7'd0, vbus_drv_evt, core_evt, 3'd0, rx_ep_evt, 4'd0, tx_ep_evt};
      if (reg_wr && reg_addr == 8'h28) m_src = m_src & ~reg_wdata;
      if (reg_wr && reg_addr == 8'h24) m_src = m_src | reg_wdata;
      m_src = (m_src | ev) & VALID;
      if (reg_wr && reg_addr == 8'h34) m_msk = m_msk & ~reg_wdata;
      if (reg_wr && reg_addr == 8'h30) m_msk = m_msk | reg_wdata;
      m_msk = m_msk & VALID;
    end
    #1;
    chk(cpu_irq === m_irq, "R6 line vs model", {31'd0, cpu_irq}, {31'd0, m_irq});
    chk(core_soft_rst === m_srst, "R8 pulse vs model", {31'd0, core_soft_rst}, {31'd0, m_srst});
    chk(reg_rdata === m_rd, "R11 read data vs model", reg_rdata, m_rd);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(posedge clk); #2;
    chk(reg_rdata === e, tag, reg_rdata, e);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cpu_irq === 0 && core_soft_rst === 0, "R1 outputs after reset",
        {30'd0, cpu_irq, core_soft_rst}, 0);
    rd_exp(8'h00, REV, "R1 identifier");
    rd_exp(8'h20, 0, "R1 event word cleared");
    rd_exp(8'h2c, 0, "R1 mask cleared");

    // R2 all event inputs for one cycle
    @(negedge clk);
    tx_ep_evt = '1; rx_ep_evt = '1; core_evt = '1; vbus_drv_evt = 1;
    @(negedge clk);
    tx_ep_evt = 0; rx_ep_evt = 0; core_evt = 0; vbus_drv_evt = 0;
    rd_exp(8'h20, VALID, "R2 event bit layout");
    @(negedge clk); rx_ep_evt = 4'b0100; @(negedge clk); rx_ep_evt = 0;
    wr(8'h28, 32'hFFFF_FFFF);
    rd_exp(8'h20, 0, "R3 clear all");
    @(negedge clk); rx_ep_evt = 4'b0100; @(negedge clk); rx_ep_evt = 0;
    rd_exp(8'h20, 32'h0000_0800, "R2 receive endpoint 3 at bit 11");
    wr(8'h24, 32'hFFFF_FFFF);
    rd_exp(8'h20, VALID, "R2 set limited to valid bits");
    wr(8'h28, 32'h0000_0003);
    rd_exp(8'h20, 32'h01FF_1E1C, "R3 write-one clear");

    // R10 read-only offsets
    wr(8'h20, 0); wr(8'h2c, 32'hFFFF_FFFF); wr(8'h38, 0); wr(8'h00, 0); wr(8'h08, 1);
    rd_exp(8'h20, 32'h01FF_1E1C, "R10 event word unchanged");
    rd_exp(8'h2c, 0, "R10 mask unchanged");
    chk(cpu_irq === 0, "R10 no line from masked-off events", {31'd0, cpu_irq}, 0);

    // R4, R5, R6
    wr(8'h30, 32'h0000_0204);
    tick();
    chk(cpu_irq === 1, "R6 line rises", {31'd0, cpu_irq}, 1);
    rd_exp(8'h2c, 32'h0000_0204, "R4 mask set");
    rd_exp(8'h38, 32'h0000_0204, "R5 masked view");
    wr(8'h28, 32'hFFFF_FFFF);
    rd_exp(8'h38, 0, "R5 masked view after clear");
    chk(cpu_irq === 1, "R6 line held after source clear", {31'd0, cpu_irq}, 1);

    // R7
    wr(8'h3c, 32'h1234_5678);
    chk(cpu_irq === 0, "R7 line drops on EOI", {31'd0, cpu_irq}, 0);
    tick(); tick();
    chk(cpu_irq === 0, "R7 stays low with nothing pending", {31'd0, cpu_irq}, 0);
    wr(8'h24, 32'h0000_0004);
    tick();
    chk(cpu_irq === 1, "R6 line rises again", {31'd0, cpu_irq}, 1);
    wr(8'h3c, 0);
    chk(cpu_irq === 0, "R7 one-cycle gap", {31'd0, cpu_irq}, 0);
    tick();
    chk(cpu_irq === 1, "R7 re-fires while pending", {31'd0, cpu_irq}, 1);

    // R3 event beats clear in the same cycle
    @(negedge clk);
    reg_wr = 1; reg_addr = 8'h28; reg_wdata = 32'h0000_0002; tx_ep_evt = 5'b00010;
    @(negedge clk);
    reg_wr = 0; tx_ep_evt = 0;
    rd_exp(8'h20, 32'h0000_0006, "R3 event wins over clear");

    wr(8'h34, 32'h0000_0004);
    rd_exp(8'h2c, 32'h0000_0200, "R4 mask clear");

    // R8
    wr(8'h04, 32'h0000_0001);
    chk(core_soft_rst === 1, "R8 soft reset pulse", {31'd0, core_soft_rst}, 1);
    tick();
    chk(core_soft_rst === 0, "R8 pulse lasts one cycle", {31'd0, core_soft_rst}, 0);
    wr(8'h04, 32'hFFFF_FFFE);
    chk(core_soft_rst === 0, "R8 no pulse with bit 0 clear", {31'd0, core_soft_rst}, 0);
    rd_exp(8'h04, 0, "R8 control reads zero");

    // R9
    @(negedge clk); vbus_drv_lvl = 1;
    rd_exp(8'h08, 1, "R9 status level high");
    @(negedge clk); vbus_drv_lvl = 0;
    rd_exp(8'h08, 0, "R9 status level low");

    // R11 hold after read
    rd_exp(8'h00, REV, "R11 read identifier");
    tick(); tick();
    chk(reg_rdata === REV, "R11 data holds", reg_rdata, REV);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule